// File: doc/BRIEF.md
# Staged Scratchpad Write Engine

This block interprets a byte stream that a bus front end has already deserialised. It runs a two-step write into a 512-byte memory. The first step is the write-scratchpad command (`0x0F`). It loads a 32-byte staging buffer: the master sends a low and a high target-address byte, and data bytes then fill the buffer from the address's low five bits upward. The block keeps a status byte that holds the offset of the last stored byte, a flag for a transaction that ended mid-byte, and a flag for a committed copy. When the data reaches the final buffer offset, the master can read back the inverted CRC16 of everything it sent.

The second step is the copy command (`0x5A`). The master must repeat both address bytes and the status byte exactly. Only then does the block stream the staged bytes into memory through a one-byte-per-cycle write port. A bus reset is signalled by `busReset`, together with the number of bits of an unfinished byte. It ends any transaction.

Top module: `scratch_write_engine`

## Requirements
- R1: After reset `statusByte` is 0x00, `memWrEn` is low and `rdValid` is low.
- R2: In a write, the byte after `0x0F` is the address low byte and the next one is the address high byte. Bits 7:1 of the high byte are cleared as it is captured, so the target address is 9 bits. A copy must echo the cleared value.
- R3: Data bytes fill buffer offsets from target-address bits 4:0 upward. A copy writes offsets start..end to memory address {target[8:5], offset}, one per cycle, in increasing order.
- R4: `statusByte` bits 4:0 hold the offset of the last stored data byte.
- R5: A `busReset` during the data phase with `busResetBits` not 0 sets `statusByte` bit 5 (partial flag). The unfinished byte is not stored.
- R6: After a data byte is stored at offset 31, the next read returns the low byte of the inverted CRC16 and the read after it returns the high byte. The CRC16 uses polynomial 0xA001 (LSB first), starts from 0, and covers the command byte, both address bytes as sent, and the data. Every other read returns 0xFF. `rdValid` follows `rdReq` by one cycle.
- R7: A copy whose three echoed bytes differ from the stored low address, high address or status writes nothing and leaves bit 7 clear.
- R8: A copy with a matching echo sets `statusByte` bit 7 and performs the memory writes.
- R9: A new `0x0F` command clears bits 7 and 5 of `statusByte`.
- R10: A copy is refused while the partial flag is set, even when the echo matches.
- R11: After an unknown command byte, further bytes are ignored until `busReset`.
- R12: Data bytes that arrive after offset 31 has been written are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | A complete byte from the master is present |
| rxByte | input | 8 | Received byte |
| busReset | input | 1 | Bus reset pulse, ends the transaction |
| busResetBits | input | 3 | Bits of an unfinished byte seen before the reset |
| rdReq | input | 1 | Master asks for one byte |
| rdValid | output | 1 | Read byte valid, one cycle after `rdReq` |
| rdByte | output | 8 | Byte returned to the master |
| statusByte | output | 8 | Copy flag (7), partial flag (5), ending offset (4:0) |
| memWrEn | output | 1 | Memory write strobe |
| memWrAddr | output | 9 | Memory write address |
| memWrData | output | 8 | Memory write data |

## Verification
The hardest case to reach is the CRC return: the buffer has to be filled exactly up to offset 31. The bench gets there by choosing a start offset of 30 and sending two data bytes. It then adds a third byte, which must be ignored. It makes three reads and checks the two inverted CRC bytes and a trailing 0xFF. On the copy side, the bench first sends an echo of the unmasked high byte and then an echo of the masked one. This shows that address clearing and copy authorisation interact as required.

// File: rtl/scratch_write_pkg.sv
package scratch_write_pkg;
  localparam logic [7:0] CMD_WRITE = 8'h0F;
  localparam logic [7:0] CMD_COPY  = 8'h5A;

  typedef enum logic [3:0] {
    S_CMD, S_WTA1, S_WTA2, S_WDATA, S_WCRC,
    S_CTA1, S_CTA2, S_CES, S_COPY, S_IGN
  } engState_t;

  typedef struct packed {
    logic crcStart;
    logic crcFeed;
    logic loadTaLow;
    logic loadTaHigh;
    logic storeData;
    logic setPf;
    logic setAa;
    logic clearFlags;
    logic startCopy;
    logic copyStep;
  } ctrlStrobe_t;
endpackage

// File: rtl/scratch_write_dp.sv
module scratch_write_dp
  import scratch_write_pkg::*;
#(
  parameter int SP_BYTES  = 32,
  parameter int ADDR_BITS = 9
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          stb,
  input  logic [7:0]           rxByte,
  output logic [7:0]           taLow,
  output logic [7:0]           taHigh,
  output logic [7:0]           statusByte,
  output logic [15:0]          crc,
  output logic                 ptrAtEnd,
  output logic                 copyLast,
  output logic [ADDR_BITS-1:0] memWrAddr,
  output logic [7:0]           memWrData
);
  localparam int OFF_W = $clog2(SP_BYTES);
  localparam int HI_BITS = ADDR_BITS - 8;
  localparam logic [7:0] HI_MASK = 8'((1 << HI_BITS) - 1);

  logic [7:0]       spMem [SP_BYTES];
  logic [OFF_W-1:0] ptr;
  logic [OFF_W-1:0] esEnd;
  logic [OFF_W-1:0] copyOff;
  logic             aaFlag;
  logic             pfFlag;

  function automatic logic [15:0] crcStep(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 16'hA001;
      else             r = r >> 1;
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crc <= '0;
    end else if (stb.crcFeed) begin
      crc <= crcStep(stb.crcStart ? 16'h0000 : crc, rxByte);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      taLow   <= '0;
      taHigh  <= '0;
      ptr     <= '0;
      esEnd   <= '0;
      aaFlag  <= 1'b0;
      pfFlag  <= 1'b0;
      copyOff <= '0;
    end else begin
      if (stb.clearFlags) begin
        aaFlag <= 1'b0;
        pfFlag <= 1'b0;
      end
      if (stb.setPf) pfFlag <= 1'b1;
      if (stb.setAa) aaFlag <= 1'b1;
      if (stb.loadTaLow) taLow <= rxByte;
      if (stb.loadTaHigh) begin
        taHigh <= rxByte & HI_MASK;
        ptr    <= taLow[OFF_W-1:0];
        esEnd  <= taLow[OFF_W-1:0];
      end
      if (stb.storeData) begin
        esEnd <= ptr;
        ptr   <= ptr + 1'b1;
      end
      if (stb.startCopy) copyOff <= taLow[OFF_W-1:0];
      else if (stb.copyStep) copyOff <= copyOff + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.storeData) spMem[ptr] <= rxByte;
  end

  assign statusByte = {aaFlag, 1'b0, pfFlag, esEnd};
  assign ptrAtEnd   = (ptr == OFF_W'(SP_BYTES - 1));
  assign copyLast   = (copyOff == esEnd);
  assign memWrAddr  = {taHigh[HI_BITS-1:0], taLow[7:OFF_W], copyOff};
  assign memWrData  = spMem[copyOff];
endmodule

// File: rtl/scratch_write_ctrl.sv
module scratch_write_ctrl
  import scratch_write_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxValid,
  input  logic [7:0]  rxByte,
  input  logic        busReset,
  input  logic [2:0]  busResetBits,
  input  logic        rdReq,
  input  logic [7:0]  taLow,
  input  logic [7:0]  taHigh,
  input  logic [7:0]  statusByte,
  input  logic [15:0] crc,
  input  logic        ptrAtEnd,
  input  logic        copyLast,
  output ctrlStrobe_t stb,
  output logic        rdValid,
  output logic [7:0]  rdByte,
  output logic        memWrEn
);
  engState_t state, nextState;
  logic      matchOk, matchNext;
  logic      rdIdx;

  always_comb begin
    stb       = '0;
    nextState = state;
    matchNext = matchOk;
    if (state == S_COPY) begin
      stb.copyStep = 1'b1;
      if (copyLast) nextState = S_IGN;
    end else if (busReset) begin
      if (state == S_WDATA && busResetBits != 3'd0) stb.setPf = 1'b1;
      nextState = S_CMD;
    end else if (state == S_WCRC) begin
      if (rdReq && rdIdx) nextState = S_IGN;
    end else if (rxValid) begin
      unique case (state)
        S_CMD: begin
          if (rxByte == CMD_WRITE) begin
            stb.crcStart   = 1'b1;
            stb.crcFeed    = 1'b1;
            stb.clearFlags = 1'b1;
            nextState      = S_WTA1;
          end else if (rxByte == CMD_COPY) begin
            nextState = S_CTA1;
          end else begin
            nextState = S_IGN;
          end
        end
        S_WTA1: begin
          stb.loadTaLow = 1'b1;
          stb.crcFeed   = 1'b1;
          nextState     = S_WTA2;
        end
        S_WTA2: begin
          stb.loadTaHigh = 1'b1;
          stb.crcFeed    = 1'b1;
          nextState      = S_WDATA;
        end
        S_WDATA: begin
          stb.storeData = 1'b1;
          stb.crcFeed   = 1'b1;
          if (ptrAtEnd) nextState = S_WCRC;
        end
        S_CTA1: begin
          matchNext = (rxByte == taLow);
          nextState = S_CTA2;
        end
        S_CTA2: begin
          matchNext = matchOk && (rxByte == taHigh);
          nextState = S_CES;
        end
        S_CES: begin
          if (matchOk && rxByte == statusByte && !statusByte[5]) begin
            stb.setAa     = 1'b1;
            stb.startCopy = 1'b1;
            nextState     = S_COPY;
          end else begin
            nextState = S_IGN;
          end
        end
        default: nextState = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_CMD;
      matchOk <= 1'b0;
      rdIdx   <= 1'b0;
      rdValid <= 1'b0;
      rdByte  <= 8'hFF;
    end else begin
      state   <= nextState;
      matchOk <= matchNext;
      rdValid <= rdReq;
      if (state != S_WCRC) rdIdx <= 1'b0;
      else if (rdReq) rdIdx <= 1'b1;
      if (rdReq) begin
        if (state == S_WCRC) rdByte <= rdIdx ? ~crc[15:8] : ~crc[7:0];
        else rdByte <= 8'hFF;
      end
    end
  end

  assign memWrEn = (state == S_COPY);
endmodule

// File: rtl/scratch_write_engine.sv
module scratch_write_engine
  import scratch_write_pkg::*;
#(
  parameter int SP_BYTES  = 32,
  parameter int ADDR_BITS = 9
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxValid,
  input  logic [7:0]           rxByte,
  input  logic                 busReset,
  input  logic [2:0]           busResetBits,
  input  logic                 rdReq,
  output logic                 rdValid,
  output logic [7:0]           rdByte,
  output logic [7:0]           statusByte,
  output logic                 memWrEn,
  output logic [ADDR_BITS-1:0] memWrAddr,
  output logic [7:0]           memWrData
);
  ctrlStrobe_t stb;
  logic [7:0]  taLow, taHigh;
  logic [15:0] crc;
  logic        ptrAtEnd, copyLast;

  scratch_write_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxByte(rxByte),
    .busReset(busReset), .busResetBits(busResetBits), .rdReq(rdReq),
    .taLow(taLow), .taHigh(taHigh), .statusByte(statusByte), .crc(crc),
    .ptrAtEnd(ptrAtEnd), .copyLast(copyLast), .stb(stb),
    .rdValid(rdValid), .rdByte(rdByte), .memWrEn(memWrEn)
  );

  scratch_write_dp #(.SP_BYTES(SP_BYTES), .ADDR_BITS(ADDR_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rxByte(rxByte),
    .taLow(taLow), .taHigh(taHigh), .statusByte(statusByte), .crc(crc),
    .ptrAtEnd(ptrAtEnd), .copyLast(copyLast),
    .memWrAddr(memWrAddr), .memWrData(memWrData)
  );
endmodule

// File: rtl/scratch_write_checker.sv
module scratch_write_checker #(
  parameter int ADDR_BITS = 9
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busReset,
  input logic                 rdReq,
  input logic                 rdValid,
  input logic [7:0]           statusByte,
  input logic                 memWrEn,
  input logic [ADDR_BITS-1:0] memWrAddr
);
  assert_write_needs_aa_R8: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> statusByte[7]);

  assert_aa_starts_copy_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusByte[7]) |-> memWrEn);

  assert_no_copy_with_pf_R10: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> !statusByte[5]);

  assert_addr_ascends_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && $past(memWrEn)) |-> (memWrAddr == $past(memWrAddr) + 1'b1));

  assert_pf_from_reset_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusByte[5]) |-> $past(busReset));

  assert_read_latency_R6: assert property (@(posedge clk) disable iff (!rstN)
    rdValid == $past(rdReq));
endmodule

bind scratch_write_engine scratch_write_checker #(.ADDR_BITS(ADDR_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .busReset(busReset), .rdReq(rdReq), .rdValid(rdValid),
  .statusByte(statusByte), .memWrEn(memWrEn), .memWrAddr(memWrAddr)
);

// File: tb/scratch_write_engine_bench.sv
module scratch_write_engine_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxValid = 1'b0;
  logic [7:0] rxByte = 8'h00;
  logic       busReset = 1'b0;
  logic [2:0] busResetBits = 3'd0;
  logic       rdReq = 1'b0;
  logic       rdValid;
  logic [7:0] rdByte;
  logic [7:0] statusByte;
  logic       memWrEn;
  logic [8:0] memWrAddr;
  logic [7:0] memWrData;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [16:0] wrQ[$];
  logic [7:0]  rdQ[$];
  logic [15:0] crcModel;

  always #4 clk = ~clk;

  scratch_write_engine u_scratch_write_engine (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxByte(rxByte),
    .busReset(busReset), .busResetBits(busResetBits), .rdReq(rdReq),
    .rdValid(rdValid), .rdByte(rdByte), .statusByte(statusByte),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData)
  );

  function automatic logic [15:0] crcAdd(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) begin
      if ((r[0] ^ d[i]) == 1'b1) r = (r >> 1) ^ 16'hA001;
      else r = r >> 1;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    rxValid = 1'b1;
    rxByte = b;
    crcModel = crcAdd(crcModel, b);
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic pulseReset(input logic [2:0] bits);
    @(negedge clk);
    busReset = 1'b1;
    busResetBits = bits;
    @(negedge clk);
    busReset = 1'b0;
    busResetBits = 3'd0;
  endtask

  task automatic readByte(input logic [7:0] exp);
    rdQ.push_back(exp);
    @(negedge clk);
    rdReq = 1'b1;
    @(negedge clk);
    rdReq = 1'b0;
  endtask

  task automatic expectWrite(input logic [8:0] a, input logic [7:0] d);
    wrQ.push_back({a, d});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // monitor: pops the scoreboard queues as results appear
  always @(negedge clk) begin
    if (rstN && memWrEn) begin
      if (wrQ.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R7 actual=write %0h:%0h expected=no write", memWrAddr, memWrData);
      end else begin
        logic [16:0] e;
        e = wrQ.pop_front();
        check("R3 memory write", {memWrAddr, memWrData}, e);
      end
    end
    if (rstN && rdValid) begin
      if (rdQ.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R6 actual=%0h expected=no read", rdByte);
      end else begin
        logic [7:0] e;
        e = rdQ.pop_front();
        check("R6 read byte", rdByte, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    crcModel = 16'h0;
    idle(3);
    check("R1 status", statusByte, 8'h00);
    check("R1 write strobe", memWrEn, 1'b0);
    check("R1 read valid", rdValid, 1'b0);
    rstN = 1'b1;
    idle(2);

    // R3 R4 R8: good write at offset 3 then matching copy
    pulseReset(3'd0);
    crcModel = 16'h0;
    sendByte(8'h0F); sendByte(8'h23); sendByte(8'h01);
    sendByte(8'hAA); sendByte(8'hBB); sendByte(8'hCC);
    pulseReset(3'd0);
    check("R4 ending offset", statusByte, 8'h05);
    expectWrite(9'h123, 8'hAA); expectWrite(9'h124, 8'hBB); expectWrite(9'h125, 8'hCC);
    sendByte(8'h5A); sendByte(8'h23); sendByte(8'h01); sendByte(8'h05);
    idle(10);
    check("R8 copy flag", statusByte, 8'h85);
    check("R3 all writes seen", wrQ.size(), 0);

    // R5 R9 R10: partial byte, then copy refused
    pulseReset(3'd0);
    sendByte(8'h0F); sendByte(8'h40); sendByte(8'hFE);
    sendByte(8'h11); sendByte(8'h22);
    pulseReset(3'd3);
    check("R5 R9 partial flag set, copy flag cleared", statusByte, 8'h21);
    sendByte(8'h5A); sendByte(8'h40); sendByte(8'h00); sendByte(8'h21);
    idle(10);
    check("R10 copy refused", statusByte, 8'h21);

    // R6 R12: fill to offset 31, read CRC, extra byte ignored
    pulseReset(3'd0);
    crcModel = 16'h0;
    sendByte(8'h0F); sendByte(8'h3E); sendByte(8'hFF);
    sendByte(8'h5C); sendByte(8'h7D);
    readByte(~crcModel[7:0]);
    readByte(~crcModel[15:8]);
    readByte(8'hFF);
    sendByte(8'h99);
    idle(2);
    check("R12 ending offset stays 31", statusByte, 8'h1F);
    pulseReset(3'd0);
    check("R6 all reads seen", rdQ.size(), 0);

    // R2 R7: echo of unmasked high byte refused
    sendByte(8'h5A); sendByte(8'h3E); sendByte(8'hFF); sendByte(8'h1F);
    idle(10);
    check("R7 copy flag clear after mismatch", statusByte, 8'h1F);
    pulseReset(3'd0);
    expectWrite(9'h13E, 8'h5C); expectWrite(9'h13F, 8'h7D);
    sendByte(8'h5A); sendByte(8'h3E); sendByte(8'h01); sendByte(8'h1F);
    idle(10);
    check("R2 masked echo accepted", statusByte, 8'h9F);
    check("R2 writes seen", wrQ.size(), 0);

    // R11: unknown command then a write command is ignored
    pulseReset(3'd0);
    sendByte(8'h33); sendByte(8'h0F); sendByte(8'h00); sendByte(8'h00); sendByte(8'h44);
    check("R11 status unchanged", statusByte, 8'h9F);
    readByte(8'hFF);
    idle(2);

    // R7 R6: short write, no CRC, wrong status echo
    pulseReset(3'd0);
    sendByte(8'h0F); sendByte(8'h05); sendByte(8'h00); sendByte(8'h01);
    readByte(8'hFF);
    pulseReset(3'd0);
    check("R9 status after new write", statusByte, 8'h05);
    sendByte(8'h5A); sendByte(8'h05); sendByte(8'h00); sendByte(8'h06);
    idle(10);
    check("R7 wrong status echo refused", statusByte, 8'h05);
    check("R6 reads seen", rdQ.size(), 0);
    finishRun();
  end
endmodule